// File: doc/BRIEF.md
# Multi-bit key code debouncer

This block sits between a 4x4 keypad scanner and the logic that consumes key codes. The scanner's raw code can flicker while the key contacts bounce. The debouncer only reports a new code once that code has been seen unchanged on a number of consecutive sample clocks. It is meant to run from the slow scan clock, around 1 kHz. At that rate a chain of sixteen samples spans roughly sixteen milliseconds of bounce.

The raw code and a key-present flag form one compared word. When no key is pressed, the code bits are forced to zero before sampling. A release therefore has to be stable for the full window before it is reported, in the same way as a press.

The incoming word passes through a chain of `DEPTH` sampling registers. Every adjacent pair of stages is compared for full-word equality, and the comparison results are ANDed to give a stable flag. When the word is stable and differs from the current output, the output register loads the newest sample and a one-cycle strobe marks the change.

Top module: `key_code_debounce`

## Requirements
- R1: While `rst_ni` is low and on the first cycles after it rises, `code_o` = 0, `valid_o` = 0 and `new_o` = 0.
- R2: The compared word is `{key_valid_i, code_i}`. Suppose it is changed just after a clock edge and then held. The outputs keep their old value through the DEPTH-th rising edge. They show the new word after the (DEPTH+1)-th rising edge.
- R3: A word that is present for fewer than DEPTH consecutive samples never reaches the outputs and raises no strobe.
- R4: `new_o` is high for exactly one cycle, in the cycle in which `{valid_o, code_o}` takes a new value.
- R5: A word held for DEPTH or more samples that equals the current output raises no strobe, and the outputs hold.
- R6: When `key_valid_i` = 0, the code bits are treated as zero, so a release is reported as `valid_o` = 0, `code_o` = 0. The release also needs DEPTH stable samples.
- R7: Equality covers every bit of the word. A change in one code bit restarts the stability count, and the delay of R2 is then counted from the last change.
- R8: The outputs change only in a cycle where `new_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock (scan clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | CODE_W | Raw key code from the scanner |
| key_valid_i | input | 1 | High while a key is pressed |
| code_o | output | CODE_W | Debounced key code |
| valid_o | output | 1 | Debounced key-present flag |
| new_o | output | 1 | One-cycle strobe on each output change |

## Verification
The hardest case to reach is a run that stops one sample short of acceptance. The chain then holds DEPTH-1 copies of the new word, yet the output must not move. The bench drives bursts of exactly DEPTH-1 samples, and also a single-bit glitch placed just before the window completes. It then checks that the output holds and that acceptance is counted again from the last change. Release handling is exercised by driving a nonzero code while the key flag is low, which must be reported as code zero.

// File: rtl/kdb_pkg.sv
package kdb_pkg;
  parameter int unsigned DEF_CODE_W = 4;
  parameter int unsigned DEF_DEPTH  = 16;
endpackage

// File: rtl/kdb_sample_chain.sv
module kdb_sample_chain #(
  parameter int unsigned W     = 5,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] newest_o,
  output logic         stable_o
);
  localparam int unsigned NCMP = DEPTH - 1;

  logic [W-1:0]    stage_q [DEPTH];
  logic [NCMP-1:0] pair_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= word_i;
      for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign pair_eq[g] = (stage_q[g+1] == stage_q[g]);
  end

  assign stable_o = &pair_eq;
  assign newest_o = stage_q[0];
endmodule

// File: rtl/kdb_out_reg.sv
module kdb_out_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cand_i,
  input  logic         stable_i,
  output logic [W-1:0] word_o,
  output logic         load_o
);
  logic take;
  assign take = stable_i && (cand_i != word_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= take;
      if (take) word_o <= cand_i;
    end
  end
endmodule

// File: rtl/key_code_debounce.sv
module key_code_debounce
  import kdb_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned DEPTH  = DEF_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              key_valid_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              new_o
);
  localparam int unsigned W = CODE_W + 1;

  logic [W-1:0] word_in, newest, word_out;
  logic         stable;

  // no-key word carries zero code bits so a release compares cleanly
  assign word_in = {key_valid_i, key_valid_i ? code_i : {CODE_W{1'b0}}};

  kdb_sample_chain #(.W(W), .DEPTH(DEPTH)) u_chain (
    .clk_i, .rst_ni,
    .word_i  (word_in),
    .newest_o(newest),
    .stable_o(stable)
  );

  kdb_out_reg #(.W(W)) u_out (
    .clk_i, .rst_ni,
    .cand_i  (newest),
    .stable_i(stable),
    .word_o  (word_out),
    .load_o  (new_o)
  );

  assign valid_o = word_out[W-1];
  assign code_o  = word_out[CODE_W-1:0];
endmodule

// File: rtl/kdb_checker.sv
module kdb_checker #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned DEPTH  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic              key_valid_i,
  input logic [CODE_W-1:0] code_o,
  input logic              valid_o,
  input logic              new_o
);
  localparam int unsigned W  = CODE_W + 1;
  localparam int unsigned RW = $clog2(DEPTH + 1);

  logic [W-1:0]  in_w, last_q;
  logic [RW-1:0] run_q;

  assign in_w = {key_valid_i, key_valid_i ? code_i : {CODE_W{1'b0}}};

  // length of the current run of identical samples, saturating at DEPTH
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      run_q  <= RW'(DEPTH);
    end else begin
      last_q <= in_w;
      if (in_w != last_q)          run_q <= RW'(1);
      else if (run_q < RW'(DEPTH)) run_q <= run_q + RW'(1);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!new_o && !valid_o && code_o == '0));

  assert_load_newest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_o |-> ({valid_o, code_o} == $past(last_q)));

  assert_full_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_o |-> ($past(run_q) >= RW'(DEPTH)));

  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_o |=> !new_o);

  assert_strobe_changes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_o |-> ({valid_o, code_o} != $past({valid_o, code_o})));

  assert_release_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (code_o == '0));

  assert_hold_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_o |-> $stable({valid_o, code_o}));
endmodule

bind key_code_debounce kdb_checker #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_kdb_chk (
  .clk_i, .rst_ni, .code_i, .key_valid_i, .code_o, .valid_o, .new_o
);

// File: tb/key_code_debounce_tb_top.sv
`timescale 1ns/1ps
module key_code_debounce_tb_top;
  localparam int CW = 4;
  localparam int DP = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] code_i = '0;
  logic          key_valid_i = 1'b0;
  logic [CW-1:0] code_o;
  logic          valid_o, new_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  key_code_debounce #(.CODE_W(CW), .DEPTH(DP)) dut_i (
    .clk_i, .rst_ni, .code_i, .key_valid_i, .code_o, .valid_o, .new_o
  );

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(string req, logic [CW+1:0] act, logic [CW+1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [CW-1:0] c);
    key_valid_i = v;
    code_i      = c;
  endtask

  // held word must appear after DP+1 edges, with a single strobe (R2, R4)
  task automatic hold_accept(logic v, logic [CW-1:0] c, logic ev, logic [CW-1:0] ec, string req);
    logic [CW+1:0] old_w;
    bit early = 1'b0;
    old_w = {new_o, valid_o, code_o};
    drive(v, c);
    for (int i = 1; i <= DP; i++) begin
      cyc();
      if ({new_o, valid_o, code_o} !== {1'b0, old_w[CW:0]}) early = 1'b1;
    end
    check({req, " R2 no early change"}, {1'b0, early}, '0);
    cyc();
    check({req, " R2 R4 update with strobe"}, {new_o, valid_o, code_o}, {1'b1, ev, ec});
    cyc();
    check({req, " R4 strobe one cycle"}, {new_o, valid_o, code_o}, {1'b0, ev, ec});
  endtask

  // drive a word for n samples; outputs must not move (R3, R5, R8)
  task automatic run_quiet(logic v, logic [CW-1:0] c, int n, logic [CW+1:0] exp, string req);
    bit bad = 1'b0;
    logic [CW+1:0] seen = exp;
    drive(v, c);
    for (int i = 0; i < n; i++) begin
      cyc();
      if ({new_o, valid_o, code_o} !== exp) begin
        bad = 1'b1;
        seen = {new_o, valid_o, code_o};
      end
    end
    check(req, seen, exp);
    if (bad) $display("  (%s deviated)", req);
  endtask

  task automatic t_reset();
    drive(1'b1, 4'h7);
    repeat (3) cyc();
    check("R1 during reset", {new_o, valid_o, code_o}, '0);
    drive(1'b0, 4'h0);
    rst_ni = 1'b1;
    cyc();
    check("R1 after release", {new_o, valid_o, code_o}, '0);
    run_quiet(1'b0, 4'h0, DP + 4, '0, "R1 R5 idle no strobe");
  endtask

  task automatic t_press();
    hold_accept(1'b1, 4'h5, 1'b1, 4'h5, "press 5");
  endtask

  task automatic t_bounce();
    logic [CW+1:0] e;
    e = {1'b0, 1'b1, 4'h5};
    run_quiet(1'b1, 4'h9, 3, e, "R3 short burst");
    run_quiet(1'b1, 4'h5, 1, e, "R3 back to held");
    run_quiet(1'b1, 4'h9, DP - 1, e, "R3 DEPTH-1 run");
    run_quiet(1'b0, 4'h0, DP - 1, e, "R3 R6 short release");
    run_quiet(1'b1, 4'h5, DP + 6, e, "R5 same word no strobe");
  endtask

  task automatic t_single_bit();
    logic [CW+1:0] e;
    e = {1'b0, 1'b1, 4'h5};
    run_quiet(1'b1, 4'hD, DP - 1, e, "R7 msb flip short");
    run_quiet(1'b1, 4'hC, 1, e, "R7 lsb glitch");
    hold_accept(1'b1, 4'hD, 1'b1, 4'hD, "R7 restart from last change");
  endtask

  task automatic t_release();
    hold_accept(1'b0, 4'hA, 1'b0, 4'h0, "R6 release masks code");
    hold_accept(1'b1, 4'h0, 1'b1, 4'h0, "R6 key 0 differs from release");
    hold_accept(1'b1, 4'hF, 1'b1, 4'hF, "press F");
    run_quiet(1'b1, 4'hF, DP, {1'b0, 1'b1, 4'hF}, "R8 R5 hold F");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_press();
    t_bounce();
    t_single_bit();
    t_release();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule